// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps time of day for a precision time protocol clock as a 64-bit count of nanoseconds. There is no separate cycle counter. On every tick of the datapath clock it adds a programmable increment. The increment is a fixed-point number: the upper 32 bits are whole nanoseconds and the lower 32 bits are a binary fraction. A 32-bit fraction accumulator holds the sub-nanosecond remainder and carries into the nanosecond count. Because of this, datapath clocks whose periods are not whole nanoseconds (1.6 ns, 3.2 ns) still keep exact long-term time.

Software reaches the block through a small word-wide register port with four addresses: time low, time high, increment low and increment high. Each 64-bit value moves as one coherent unit:

- Reading the time low word captures the upper half into a shadow register. A later high-word read returns that captured value.
- A low-word write, to either the time or the increment, is held pending. It takes effect only together with the matching high-word write.

A link-speed input selects a default increment, which is loaded on a pulse. At the slowest link speed timekeeping is unsupported, so the counter stops. A run input gates counting.

Top module: `tod_counter`

## Requirements
- R1: After reset the time reads 0, the fraction accumulator is 0, and the active increment is 0x0000_0001_9999_9999 (1.6 ns). Reads return it as 0x99999999 at the increment-low address and 0x00000001 at the increment-high address.
- R2: On each clock edge where counting is enabled, a new 32-bit fraction is formed as the old fraction plus the increment's low word. The time advances by the increment's high word plus the carry out of that fraction addition.
- R3: The register addresses are 0 = time low, 1 = time high, 2 = increment low, 3 = increment high. A read at address 0 returns the time low word as it stood at that edge and captures the upper 32 bits of that same value. A later read at address 1 returns the captured word, however far the time has moved since.
- R4: A write to address 0 only stores a pending low word. It leaves the running time unchanged.
- R5: A write to address 1 loads the time with {written word, pending low word} on that edge and clears the fraction accumulator.
- R6: A write to address 2 only stores a pending increment low word and does not change the counting rate. A write to address 3 makes {written word, pending low word} the active increment.
- R7: A one-cycle loadDefault pulse sets the active increment from linkSpeed: 0 (40G or no link) gives 0x0199999999, 1 (10G) gives 0x0333333333, 2 (1G) gives 0x2000000000, and 3 (100M) gives 0. An increment-high write on the same edge wins.
- R8: While linkSpeed is 3 (100M) the time does not advance, whatever runEn is.
- R9: While runEn is low the time holds its value, but time and increment writes are still accepted.
- R10: A time load (address 1 write) on an edge where counting is enabled takes priority: the time becomes exactly the written value, with no increment added.
- R11: regRdata updates only on an edge where regRd is high, one cycle after the read is presented, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock; each edge is one tick |
| rstN | input | 1 | Synchronous active-low reset |
| runEn | input | 1 | Counting enable |
| linkSpeed | input | 2 | Link speed code: 0 = 40G or none, 1 = 10G, 2 = 1G, 3 = 100M |
| loadDefault | input | 1 | Pulse: load the default increment for linkSpeed |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid the cycle after regRd |

## Verification
Assertions check the following on every cycle:

- the per-tick advance, which is the increment's whole part plus at most one carry;
- the hold conditions for a low link speed and for a stopped counter;
- the priority of a time load;
- the lack of effect of a lone low-word increment write;
- default increment selection;
- stability of the read data between reads.

The fractional carry pattern over many ticks can only be shown by the bench scenarios. The same holds for the coherence of a captured high word while the time keeps running, and for the interplay of pending low words with later high writes. The bench shows these through exact time values read back after counted runs and through a long mixed random sequence.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int REG_W  = 32;
  localparam int TIME_W = 2 * REG_W;

  typedef enum logic [1:0] {
    SPEED_40G  = 2'd0,
    SPEED_10G  = 2'd1,
    SPEED_1G   = 2'd2,
    SPEED_100M = 2'd3
  } linkSpeed_e;

  typedef enum logic [1:0] {
    ADDR_TIME_LO = 2'd0,
    ADDR_TIME_HI = 2'd1,
    ADDR_INC_LO  = 2'd2,
    ADDR_INC_HI  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic timeLoad;
    logic incLoad;
    logic incDefault;
    logic rdTimeLo;
    logic rdTimeHi;
    logic rdIncLo;
    logic rdIncHi;
    logic advance;
  } todStrobe_t;

  function automatic logic [TIME_W-1:0] defaultInc(input logic [1:0] speed);
    logic [TIME_W-1:0] v;
    case (speed)
      SPEED_40G: v = 64'h0000_0001_9999_9999;
      SPEED_10G: v = 64'h0000_0003_3333_3333;
      SPEED_1G:  v = 64'h0000_0020_0000_0000;
      default:   v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int WORD_W = REG_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic [1:0]          linkSpeed,
  input  logic                loadDefault,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [1:0]          regAddr,
  input  logic [WORD_W-1:0]   regWdata,
  output todStrobe_t          strobe,
  output logic [2*WORD_W-1:0] timeLoadVal,
  output logic [2*WORD_W-1:0] incLoadVal
);

  logic [WORD_W-1:0] pendTimeLo;
  logic [WORD_W-1:0] pendIncLo;
  logic              wrTimeLo, wrTimeHi, wrIncLo, wrIncHi;
  logic              speedOk;

  assign wrTimeLo = regWr && (regAddr == ADDR_TIME_LO);
  assign wrTimeHi = regWr && (regAddr == ADDR_TIME_HI);
  assign wrIncLo  = regWr && (regAddr == ADDR_INC_LO);
  assign wrIncHi  = regWr && (regAddr == ADDR_INC_HI);
  assign speedOk  = (linkSpeed != SPEED_100M);

  // Pending low halves: held until the matching high write commits them.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendTimeLo <= '0;
      pendIncLo  <= '0;
    end else begin
      if (wrTimeLo) pendTimeLo <= regWdata;
      if (wrIncLo)  pendIncLo  <= regWdata;
    end
  end

  assign timeLoadVal = {regWdata, pendTimeLo};
  assign incLoadVal  = {regWdata, pendIncLo};

  always_comb begin
    strobe            = '0;
    strobe.timeLoad   = wrTimeHi;
    strobe.incLoad    = wrIncHi;
    strobe.incDefault = loadDefault && !wrIncHi;
    strobe.rdTimeLo   = regRd && (regAddr == ADDR_TIME_LO);
    strobe.rdTimeHi   = regRd && (regAddr == ADDR_TIME_HI);
    strobe.rdIncLo    = regRd && (regAddr == ADDR_INC_LO);
    strobe.rdIncHi    = regRd && (regAddr == ADDR_INC_HI);
    // A time load on the same tick overrides the increment.
    strobe.advance    = runEn && speedOk && !wrTimeHi;
  end

endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int WORD_W = REG_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  todStrobe_t          strobe,
  input  logic [1:0]          linkSpeed,
  input  logic [2*WORD_W-1:0] timeLoadVal,
  input  logic [2*WORD_W-1:0] incLoadVal,
  output logic [WORD_W-1:0]   regRdata,
  output logic [2*WORD_W-1:0] timeNow,
  output logic [2*WORD_W-1:0] incNow
);

  localparam int FULL_W = 2 * WORD_W;

  logic [FULL_W-1:0] timeReg;
  logic [FULL_W-1:0] incReg;
  logic [WORD_W-1:0] fracReg;
  logic [WORD_W-1:0] shadowHi;
  logic [WORD_W-1:0] rdReg;

  logic [WORD_W:0]   fracSum;
  logic [FULL_W-1:0] timeStep;

  assign fracSum  = {1'b0, fracReg} + {1'b0, incReg[WORD_W-1:0]};
  assign timeStep = {{WORD_W{1'b0}}, incReg[FULL_W-1:WORD_W]}
                  + {{(FULL_W-1){1'b0}}, fracSum[WORD_W]};

  // Time and fraction accumulator.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeReg <= '0;
      fracReg <= '0;
    end else if (strobe.timeLoad) begin
      timeReg <= timeLoadVal;
      fracReg <= '0;
    end else if (strobe.advance) begin
      timeReg <= timeReg + timeStep;
      fracReg <= fracSum[WORD_W-1:0];
    end
  end

  // Active increment.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      incReg <= defaultInc(SPEED_40G);
    end else if (strobe.incLoad) begin
      incReg <= incLoadVal;
    end else if (strobe.incDefault) begin
      incReg <= defaultInc(linkSpeed);
    end
  end

  // Read path with coherent capture of the upper time word.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowHi <= '0;
      rdReg    <= '0;
    end else begin
      if (strobe.rdTimeLo) begin
        rdReg    <= timeReg[WORD_W-1:0];
        shadowHi <= timeReg[FULL_W-1:WORD_W];
      end else if (strobe.rdTimeHi) begin
        rdReg <= shadowHi;
      end else if (strobe.rdIncLo) begin
        rdReg <= incReg[WORD_W-1:0];
      end else if (strobe.rdIncHi) begin
        rdReg <= incReg[FULL_W-1:WORD_W];
      end
    end
  end

  assign regRdata = rdReg;
  assign timeNow  = timeReg;
  assign incNow   = incReg;

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int WORD_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [1:0]        linkSpeed,
  input  logic              loadDefault,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata
);

  localparam int FULL_W = 2 * WORD_W;

  todStrobe_t        strobe;
  logic [FULL_W-1:0] timeLoadVal;
  logic [FULL_W-1:0] incLoadVal;
  logic [FULL_W-1:0] timeNow;
  logic [FULL_W-1:0] incNow;

  tod_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .linkSpeed(linkSpeed),
    .loadDefault(loadDefault), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .strobe(strobe),
    .timeLoadVal(timeLoadVal), .incLoadVal(incLoadVal)
  );

  tod_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .linkSpeed(linkSpeed),
    .timeLoadVal(timeLoadVal), .incLoadVal(incLoadVal),
    .regRdata(regRdata), .timeNow(timeNow), .incNow(incNow)
  );

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
#(
  parameter int WORD_W = REG_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                runEn,
  input logic [1:0]          linkSpeed,
  input logic                loadDefault,
  input logic                regWr,
  input logic                regRd,
  input logic [1:0]          regAddr,
  input logic [WORD_W-1:0]   regWdata,
  input logic [WORD_W-1:0]   regRdata,
  input logic [2*WORD_W-1:0] timeNow,
  input logic [2*WORD_W-1:0] incNow
);

  localparam int FULL_W = 2 * WORD_W;

  logic wrHi, wrIncLo, wrIncHi, rdLo;
  logic [FULL_W-1:0] stepSeen;
  logic [FULL_W-1:0] stepWhole;

  assign wrHi    = regWr && (regAddr == 2'd1);
  assign wrIncLo = regWr && (regAddr == 2'd2);
  assign wrIncHi = regWr && (regAddr == 2'd3);
  assign rdLo    = regRd && (regAddr == 2'd0);

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && linkSpeed != 2'd3 && !wrHi) |=>
      (timeNow - $past(timeNow) - {{WORD_W{1'b0}}, $past(incNow[FULL_W-1:WORD_W])}) <= 1); // R2

  AST_CAPTURE_LO: assert property (@(posedge clk) disable iff (!rstN)
    rdLo |=> regRdata == $past(timeNow[WORD_W-1:0])); // R3

  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrHi |=> timeNow[FULL_W-1:WORD_W] == $past(regWdata)); // R5 R10

  AST_INC_LO_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (wrIncLo && !loadDefault) |=> $stable(incNow)); // R6

  AST_DEFAULT_INC: assert property (@(posedge clk) disable iff (!rstN)
    (loadDefault && !wrIncHi) |=> incNow == defaultInc($past(linkSpeed))); // R7

  AST_SLOW_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (linkSpeed == 2'd3 && !wrHi) |=> $stable(timeNow)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !wrHi) |=> $stable(timeNow)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> $stable(regRdata)); // R11

endmodule

bind tod_counter tod_counter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .linkSpeed(linkSpeed),
  .loadDefault(loadDefault), .regWr(regWr), .regRd(regRd),
  .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
  .timeNow(timeNow), .incNow(incNow)
);

// File: tb/tod_counter_tb.sv
`timescale 1ns/1ps
module tod_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [1:0]  linkSpeed = 2'd0;
  logic        loadDefault = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tod_counter u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .linkSpeed(linkSpeed),
    .loadDefault(loadDefault), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  // Expected default increment per speed code (R7).
  function automatic logic [63:0] benchDefault(input logic [1:0] s);
    case (s)
      2'd0: return 64'h01_9999_9999;
      2'd1: return 64'h03_3333_3333;
      2'd2: return 64'h20_0000_0000;
      default: return 64'h0;
    endcase
  endfunction

  // Reference model built from the requirements.
  logic [63:0] mTime, mInc;
  logic [31:0] mFrac, mShadow, mPendT, mPendI, expRd;

  always @(posedge clk) begin
    logic [32:0] fs;
    if (!rstN) begin
      mTime <= '0; mFrac <= '0; mInc <= 64'h1_9999_9999;
      mShadow <= '0; mPendT <= '0; mPendI <= '0; expRd <= '0;
    end else begin
      if (regRd) begin
        case (regAddr)
          2'd0: begin expRd <= mTime[31:0]; mShadow <= mTime[63:32]; end
          2'd1: expRd <= mShadow;
          2'd2: expRd <= mInc[31:0];
          default: expRd <= mInc[63:32];
        endcase
      end
      fs = {1'b0, mFrac} + {1'b0, mInc[31:0]};
      if (runEn && linkSpeed != 2'd3) begin
        mTime <= mTime + {32'b0, mInc[63:32]} + {63'b0, fs[32]};
        mFrac <= fs[31:0];
      end
      if (loadDefault) mInc <= benchDefault(linkSpeed);
      if (regWr) begin
        case (regAddr)
          2'd0: mPendT <= regWdata;
          2'd1: begin mTime <= {regWdata, mPendT}; mFrac <= '0; end
          2'd2: mPendI <= regWdata;
          default: mInc <= {regWdata, mPendI};
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; presents one cycle of port activity.
  task automatic op(input bit wr, input bit rd, input logic [1:0] a, input logic [31:0] d);
    regWr = wr; regRd = rd; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regRd = 1'b0;
  endtask

  task automatic runTicks(input int n);
    runEn = 1'b1;
    repeat (n) @(negedge clk);
    runEn = 1'b0;
  endtask

  task automatic pulseDefault();
    loadDefault = 1'b1;
    @(negedge clk);
    loadDefault = 1'b0;
  endtask

  task automatic readTimeLo(input string tag, input logic [31:0] exp);
    op(0, 1, 2'd0, 0);
    chk(tag, regRdata, exp);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    op(0, 1, 2'd2, 0); chk("R1 inc lo", regRdata, 32'h9999_9999);
    op(0, 1, 2'd3, 0); chk("R1 inc hi", regRdata, 32'h1);
    readTimeLo("R1 time lo", 32'h0);
    op(0, 1, 2'd1, 0); chk("R1 time hi", regRdata, 32'h0);

    // R4 pending low, R5 commit, R9 writes accepted while stopped
    op(1, 0, 2'd0, 32'h10);
    readTimeLo("R4 lone low write", 32'h0);
    op(1, 0, 2'd1, 32'h0);
    readTimeLo("R5 R9 committed time", 32'h10);

    // R2 fractional carry: 0.5 ns per tick
    op(1, 0, 2'd2, 32'h8000_0000);
    op(1, 0, 2'd3, 32'h0);
    runTicks(4);
    readTimeLo("R2 half-ns ticks", 32'h12);

    // R6 lone increment low write does not change the rate
    op(1, 0, 2'd2, 32'h0);
    runTicks(4);
    readTimeLo("R6 pending inc lo", 32'h14);
    op(1, 0, 2'd3, 32'h3);
    runTicks(2);
    readTimeLo("R6 committed inc", 32'h1A);

    // R7 default for 1G
    linkSpeed = 2'd2;
    pulseDefault();
    op(0, 1, 2'd3, 0); chk("R7 1G inc hi", regRdata, 32'h20);
    runTicks(3);
    readTimeLo("R7 32ns ticks", 32'h7A);

    // R8 100M stops the clock
    linkSpeed = 2'd3;
    runTicks(5);
    readTimeLo("R8 stopped at 100M", 32'h7A);
    linkSpeed = 2'd1;
    pulseDefault();
    op(0, 1, 2'd2, 0); chk("R7 10G inc lo", regRdata, 32'h3333_3333);

    // R10 priority of a time load, R3 coherent capture while running
    linkSpeed = 2'd2;
    pulseDefault();
    op(1, 0, 2'd0, 32'hFFFF_FFF0);
    runEn = 1'b1;
    op(1, 0, 2'd1, 32'h1);
    readTimeLo("R10 load beats increment", 32'hFFFF_FFF0);
    op(0, 0, 2'd0, 0);
    op(0, 0, 2'd0, 0);
    op(0, 1, 2'd1, 0); chk("R3 captured hi", regRdata, 32'h1);
    runEn = 1'b0;
    readTimeLo("R3 after wrap lo", 32'h70);
    op(0, 1, 2'd1, 0); chk("R3 after wrap hi", regRdata, 32'h2);

    // R11 read data holds without a read
    op(0, 0, 2'd0, 0); op(1, 0, 2'd3, 32'h7); op(0, 0, 2'd0, 0);
    chk("R11 rdata hold", regRdata, 32'h2);

    // Mixed random phase against the model
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      bit didRd;
      r = $urandom;
      runEn = (r[1:0] != 2'd0);
      if (r[9:3] == 7'd0) linkSpeed = r[11:10];
      loadDefault = (r[16:12] == 5'd0);
      regWr = (r[19:17] < 3'd2);
      regRd = (r[22:20] < 3'd3);
      regAddr = r[24:23];
      regWdata = (r[25]) ? $urandom : {24'hFFFFFF, $urandom_range(255, 0)};
      didRd = regRd;
      @(negedge clk);
      regWr = 1'b0; regRd = 1'b0; loadDefault = 1'b0;
      if (didRd) chk("R2 R3 R5 R6 R7 random read", regRdata, expRd);
    end
    runEn = 1'b0;
    op(0, 1, 2'd0, 0); chk("R3 final time lo", regRdata, expRd);
    op(0, 1, 2'd1, 0); chk("R3 final time hi", regRdata, expRd);

    finishRun();
  end

endmodule